// File: doc/BRIEF.md
# Configurable Product-Term Plane with Term Steering

This block is the sum-of-products core of one programmable logic block. Thirty-six routed signals enter and each is offered as a pair of literals, one true and one inverted. Eighty-six product terms are formed from these literals. Each term is the AND of whichever literals its mask selects. A steering matrix then hands the terms to sixteen macrocell feeds. Each feed may take no terms or any number up to sixteen. A single term may be handed to any number of feeds at once, so a term common to several equations is built only once.

Every feed leaves the block twice. The first form is a sixteen-slot vector holding its steered terms in ascending term order. The second form is the OR of that vector. A per-feed flag reports a steering row that selects more than the sixteen terms a feed can take. The path from the routed signals to the outputs is purely combinational. The masks, the empty-term enables and the steering rows are held in registers. These are loaded one 32-bit word at a time through an address/data write port.

Top module: `pterm_steer_array`

## Requirements
- R1: Routed input i produces literal 2i equal to its value and literal 2i+1 equal to its inverse. This gives 72 literals for 36 inputs.
- R2: Each of the 86 product terms is the AND of every literal whose bit is set in that term's 72-bit literal mask.
- R3: A term with an all-zero literal mask evaluates to 1 when its empty-term enable bit is set. It evaluates to 0 when that bit is clear.
- R4: `sum_o[m]` is the OR of the terms steered to macrocell m. A macrocell with no selected terms outputs 0.
- R5: A term selected in several steering rows drives every one of those macrocells in the same cycle.
- R6: When a steering row selects more than 16 terms, `over_o[m]` is 1 and only the 16 lowest-indexed selected terms reach slots and sum. Otherwise `over_o[m]` is 0.
- R7: Slot s of macrocell m, which is bit m*16+s of `steer_o`, carries the s-th lowest-indexed selected term (counting from 0). Slots beyond the number of selected terms are 0.
- R8: A write with `cfg_addr[9]`=0 targets term `cfg_addr[8:2]`, and word `cfg_addr[1:0]` covers packed bits 32w..32w+31. Packed bits 0..71 are the literal mask and bit 72 is the empty-term enable, so word 2 bit 8 holds the enable. A write with `cfg_addr[9]`=1 targets the steering row of macrocell `cfg_addr[5:2]`, and word w covers term bits 32w..32w+31. Bits that fall beyond the stored width, term indices of 86 or more, and steering writes with a nonzero `cfg_addr[8:6]` are ignored. A write becomes visible after the clock edge that captures it and not before.
- R9: With configuration unchanged, the outputs follow `pin_i` in the same cycle, with no register on the path.
- R10: While reset is low, all masks, enables and steering rows clear. All sums, slots and flags are therefore 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low reset, clears all configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 10 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| pin_i | input | 36 | Routed input signals |
| sum_o | output | 16 | OR of the steered terms per macrocell |
| over_o | output | 16 | Steering row selects more than 16 terms |
| steer_o | output | 256 | Steered term slots, 16 per macrocell |

## Verification
Two functions can land in the same cycle: term sharing, where one term feeds several macrocells, and overflow truncation, where a row loses its higher-indexed terms. Randomised configurations set every fourth steering row dense, so that it exceeds sixteen terms. Those rows draw on the same terms that sparser rows also select. A single term can therefore be kept in one macrocell's slots and dropped from another's in the same evaluation. The bench judges each macrocell against a reference model built from the requirements. That model ranks the selected terms and truncates them per row. All 256 slot bits, the sums and the flags are compared after every input change. A directed sweep also walks a one-hot input across a 20-term row, to confirm the cut falls exactly at slot 16.

// File: rtl/ptm_pkg.sv
`timescale 1ns/1ps
package ptm_pkg;

  localparam int CFG_DW = 32;

  typedef enum logic {
    CFG_TERM  = 1'b0,
    CFG_STEER = 1'b1
  } cfg_region_e;

  // Number of configuration words needed to cover a packed field
  function automatic int words_for(input int bits);
    return (bits + CFG_DW - 1) / CFG_DW;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ptm_cfg_regs.sv
`timescale 1ns/1ps
module ptm_cfg_regs
  import ptm_pkg::*;
#(
  parameter int NUM_PT = 86,
  parameter int LIT_N  = 72,
  parameter int NUM_MC = 16,
  parameter int IDX_W  = 7,
  localparam int ADDR_W = IDX_W + 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [CFG_DW-1:0]              wdata_i,
  output logic [NUM_PT-1:0][LIT_N-1:0]   lit_mask_o,
  output logic [NUM_PT-1:0]              term_en_o,
  output logic [NUM_MC-1:0][NUM_PT-1:0]  steer_o
);

  localparam int MC_W = (NUM_MC > 1) ? $clog2(NUM_MC) : 1;
  localparam int W0   = (LIT_N < CFG_DW) ? LIT_N : CFG_DW;

  cfg_region_e       region;
  logic [1:0]        wsel;
  logic [IDX_W-1:0]  idx;
  logic              term_hit;
  logic              steer_hit;

  logic [NUM_PT-1:0][LIT_N-1:0]  lit_q;
  logic [NUM_PT-1:0]             en_q;
  logic [NUM_MC-1:0][NUM_PT-1:0] steer_q;

  always_comb begin
    region    = cfg_region_e'(addr_i[ADDR_W-1]);
    wsel      = addr_i[1:0];
    idx       = addr_i[ADDR_W-2:2];
    term_hit  = (region == CFG_TERM) && (int'(idx) < NUM_PT);
    steer_hit = (region == CFG_STEER) && (int'(idx) < NUM_MC) &&
                ((idx >> MC_W) == '0);
  end

  // Packed term word: literal mask bits 0..LIT_N-1, then the enable at LIT_N
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lit_q   <= '0;
      en_q    <= '0;
      steer_q <= '0;
    end else if (we_i) begin
      for (int b = 0; b < CFG_DW; b++) begin
        if (term_hit) begin
          if ((int'(wsel) * CFG_DW + b) < LIT_N)
            lit_q[idx][int'(wsel) * CFG_DW + b] <= wdata_i[b];
          else if ((int'(wsel) * CFG_DW + b) == LIT_N)
            en_q[idx] <= wdata_i[b];
        end
        if (steer_hit) begin
          if ((int'(wsel) * CFG_DW + b) < NUM_PT)
            steer_q[idx[MC_W-1:0]][int'(wsel) * CFG_DW + b] <= wdata_i[b];
        end
      end
    end
  end

  assign lit_mask_o = lit_q;
  assign term_en_o  = en_q;
  assign steer_o    = steer_q;

  // R8: a first-word write to a term lands in its mask on the next edge
  p_term_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && term_hit && wsel == 2'd0) |=>
      (lit_mask_o[$past(idx)][W0-1:0] == $past(wdata_i[W0-1:0])));

  // R8: configuration holds when no write is presented
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> ($stable(steer_o) && $stable(term_en_o)));

endmodule

// File: rtl/ptm_and_plane.sv
`timescale 1ns/1ps
module ptm_and_plane #(
  parameter int NUM_IN = 36,
  parameter int NUM_PT = 86,
  localparam int LIT_N = 2 * NUM_IN
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_IN-1:0]             pin_i,
  input  logic [NUM_PT-1:0][LIT_N-1:0]  lit_mask_i,
  input  logic [NUM_PT-1:0]             term_en_i,
  output logic [NUM_PT-1:0]             term_o
);

  logic [LIT_N-1:0] lits;

  // Even literal is the input, odd literal its inverse
  always_comb begin
    for (int i = 0; i < NUM_IN; i++) begin
      lits[2*i]   = pin_i[i];
      lits[2*i+1] = ~pin_i[i];
    end
  end

  function automatic logic eval_term(input logic [LIT_N-1:0] l,
                                     input logic [LIT_N-1:0] m,
                                     input logic             en);
    logic used;
    used = |m;
    return used ? &(l | ~m) : en;
  endfunction

  for (genvar t = 0; t < NUM_PT; t++) begin : g_term
    assign term_o[t] = eval_term(lits, lit_mask_i[t], term_en_i[t]);

    // R3: an empty term without its enable stays low
    p_empty_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((lit_mask_i[t] == '0) && !term_en_i[t]) |-> !term_o[t]);
  end

endmodule

// File: rtl/ptm_steer_slice.sv
`timescale 1ns/1ps
module ptm_steer_slice #(
  parameter int NUM_PT = 86,
  parameter int MAX_PT = 16,
  localparam int CW = $clog2(NUM_PT + 1),
  localparam int SW = (MAX_PT > 1) ? $clog2(MAX_PT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_PT-1:0] term_i,
  input  logic [NUM_PT-1:0] sel_i,
  output logic [MAX_PT-1:0] slots_o,
  output logic              sum_o,
  output logic              over_o
);

  // rank[k] = number of selected terms with index below k
  logic [CW-1:0] rank [NUM_PT+1];

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] r,
                                         input logic s);
    return r + CW'(s);
  endfunction

  always_comb begin
    rank[0] = '0;
    for (int k = 0; k < NUM_PT; k++)
      rank[k+1] = bump(rank[k], sel_i[k]);
  end

  always_comb begin
    slots_o = '0;
    for (int k = 0; k < NUM_PT; k++) begin
      if (sel_i[k] && (int'(rank[k]) < MAX_PT))
        slots_o[rank[k][SW-1:0]] = slots_o[rank[k][SW-1:0]] | term_i[k];
    end
  end

  assign over_o = int'(rank[NUM_PT]) > MAX_PT;
  assign sum_o  = |slots_o;

  // R4: a high sum always has a selected term that is high
  p_sum_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sum_o |-> |(term_i & sel_i));

  // R6: without overflow nothing selected is dropped
  p_sum_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !over_o |-> (sum_o == |(term_i & sel_i)));

  // R7: the top slot is empty while fewer than MAX_PT terms are selected
  p_unused_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rank[NUM_PT]) < MAX_PT) |-> !slots_o[MAX_PT-1]);

endmodule

// File: rtl/ptm_alloc.sv
`timescale 1ns/1ps
module ptm_alloc #(
  parameter int NUM_PT = 86,
  parameter int NUM_MC = 16,
  parameter int MAX_PT = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_PT-1:0]              term_i,
  input  logic [NUM_MC-1:0][NUM_PT-1:0]  steer_i,
  output logic [NUM_MC-1:0][MAX_PT-1:0]  slots_o,
  output logic [NUM_MC-1:0]              sum_o,
  output logic [NUM_MC-1:0]              over_o
);

  for (genvar m = 0; m < NUM_MC; m++) begin : g_mc
    ptm_steer_slice #(
      .NUM_PT (NUM_PT),
      .MAX_PT (MAX_PT)
    ) slice_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .term_i  (term_i),
      .sel_i   (steer_i[m]),
      .slots_o (slots_o[m]),
      .sum_o   (sum_o[m]),
      .over_o  (over_o[m])
    );
  end

  // R5: a term shared by two rows reaches both when neither overflows
  if (NUM_MC > 1) begin : g_share_chk
    p_shared_term_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!over_o[0] && !over_o[1] && |(steer_i[0] & steer_i[1] & term_i))
        |-> (sum_o[0] && sum_o[1]));
  end

endmodule

// File: rtl/pterm_steer_array.sv
`timescale 1ns/1ps
module pterm_steer_array
  import ptm_pkg::*;
#(
  parameter int NUM_IN = 36,
  parameter int NUM_PT = 86,
  parameter int NUM_MC = 16,
  parameter int MAX_PT = 16,
  localparam int LIT_N  = 2 * NUM_IN,
  localparam int IDX_W  = max_int($clog2(NUM_PT), $clog2(NUM_MC)),
  localparam int ADDR_W = IDX_W + 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [ADDR_W-1:0]        cfg_addr,
  input  logic [CFG_DW-1:0]        cfg_wdata,
  input  logic [NUM_IN-1:0]        pin_i,
  output logic [NUM_MC-1:0]        sum_o,
  output logic [NUM_MC-1:0]        over_o,
  output logic [NUM_MC*MAX_PT-1:0] steer_o
);

  logic [NUM_PT-1:0][LIT_N-1:0]  lit_mask;
  logic [NUM_PT-1:0]             term_en;
  logic [NUM_MC-1:0][NUM_PT-1:0] steer_cfg;
  logic [NUM_PT-1:0]             terms;
  logic [NUM_MC-1:0][MAX_PT-1:0] slots;

  ptm_cfg_regs #(
    .NUM_PT (NUM_PT),
    .LIT_N  (LIT_N),
    .NUM_MC (NUM_MC),
    .IDX_W  (IDX_W)
  ) cfg_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_i       (cfg_we),
    .addr_i     (cfg_addr),
    .wdata_i    (cfg_wdata),
    .lit_mask_o (lit_mask),
    .term_en_o  (term_en),
    .steer_o    (steer_cfg)
  );

  ptm_and_plane #(
    .NUM_IN (NUM_IN),
    .NUM_PT (NUM_PT)
  ) plane_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      (pin_i),
    .lit_mask_i (lit_mask),
    .term_en_i  (term_en),
    .term_o     (terms)
  );

  ptm_alloc #(
    .NUM_PT (NUM_PT),
    .NUM_MC (NUM_MC),
    .MAX_PT (MAX_PT)
  ) alloc_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .term_i  (terms),
    .steer_i (steer_cfg),
    .slots_o (slots),
    .sum_o   (sum_o),
    .over_o  (over_o)
  );

  assign steer_o = slots;

  // R9: with inputs and configuration unchanged, outputs do not move
  p_comb_path_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(pin_i) && !$past(cfg_we)) |-> ($stable(sum_o) && $stable(steer_o)));

  // R10: right after reset no macrocell reports overflow
  p_reset_clear_r10: assert property (@(posedge clk)
    $rose(rst_n) |-> (over_o == '0));

endmodule

// File: tb/pterm_steer_array_tb.sv
`timescale 1ns/1ps
module pterm_steer_array_tb_top;

  localparam int NI = 36;
  localparam int NP = 86;
  localparam int NM = 16;
  localparam int MX = 16;
  localparam int NL = 2 * NI;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [9:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [NI-1:0] pin_i = '0;
  logic [NM-1:0] sum_o;
  logic [NM-1:0] over_o;
  logic [NM*MX-1:0] steer_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference configuration kept by the bench
  logic [NL-1:0] m_mask [NP];
  logic          m_en   [NP];
  logic [NP-1:0] m_row  [NM];

  logic [NM-1:0]    e_sum;
  logic [NM-1:0]    e_over;
  logic [NM*MX-1:0] e_slots;

  always #4 clk = ~clk;

  pterm_steer_array dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .pin_i     (pin_i),
    .sum_o     (sum_o),
    .over_o    (over_o),
    .steer_o   (steer_o)
  );

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_term(input int t, input logic [NL-1:0] mk, input logic en);
    wr(10'(t * 4 + 0), mk[31:0]);
    wr(10'(t * 4 + 1), mk[63:32]);
    wr(10'(t * 4 + 2), {23'd0, en, mk[71:64]});
    m_mask[t] = mk;
    m_en[t]   = en;
  endtask

  task automatic set_row(input int m, input logic [NP-1:0] r);
    wr(10'(512 + m * 4 + 0), r[31:0]);
    wr(10'(512 + m * 4 + 1), r[63:32]);
    wr(10'(512 + m * 4 + 2), {10'd0, r[85:64]});
    m_row[m] = r;
  endtask

  task automatic drive_pin(input logic [NI-1:0] p);
    @(negedge clk);
    pin_i = p;
    #1;
  endtask

  task automatic calc();
    logic [NP-1:0] tv;
    for (int t = 0; t < NP; t++) begin
      logic ok;
      logic any;
      ok = 1'b1; any = 1'b0;
      for (int l = 0; l < NL; l++) begin
        if (m_mask[t][l]) begin
          any = 1'b1;
          if (((l % 2) == 1) ? pin_i[l/2] : ~pin_i[l/2]) ok = 1'b0;
        end
      end
      tv[t] = any ? ok : m_en[t];
    end
    e_slots = '0;
    for (int m = 0; m < NM; m++) begin
      int n;
      n = 0;
      for (int t = 0; t < NP; t++) begin
        if (m_row[m][t]) begin
          if (n < MX) e_slots[m*MX + n] = tv[t];
          n++;
        end
      end
      e_over[m] = (n > MX);
      e_sum[m]  = |e_slots[m*MX +: MX];
    end
  endtask

  task automatic check_all(input string tag);
    calc();
    checks++;
    if (sum_o !== e_sum) begin
      errors++;
      $display("FAIL %s sum_o actual=%h expected=%h", tag, sum_o, e_sum);
    end
    checks++;
    if (over_o !== e_over) begin
      errors++;
      $display("FAIL %s over_o actual=%h expected=%h", tag, over_o, e_over);
    end
    checks++;
    if (steer_o !== e_slots) begin
      errors++;
      $display("FAIL %s steer_o actual=%h expected=%h", tag, steer_o, e_slots);
    end
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    for (int t = 0; t < NP; t++) begin m_mask[t] = '0; m_en[t] = 1'b0; end
    for (int m = 0; m < NM; m++) m_row[m] = '0;

    repeat (3) @(negedge clk);
    pin_i = 36'hF_0F0F_0F0F;
    #1;
    // R10: reset clears everything
    check_all("R10 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_all("R10 after reset");

    // R8: write visible only after its capturing edge
    set_term(0, 72'd1, 1'b0);
    drive_pin(36'd1);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 10'd512; cfg_wdata = 32'd1;
    #1;
    check_bit("R8 before edge", sum_o[0], 1'b0);
    @(negedge clk);
    cfg_we = 1'b0;
    m_row[0] = 86'd1;
    #1;
    check_bit("R8 after edge", sum_o[0], 1'b1);
    check_all("R8 full");

    // R1: each literal polarity of each input
    for (int i = 0; i < NI; i++) begin
      for (int pol = 0; pol < 2; pol++) begin
        logic [NL-1:0] mk;
        mk = '0;
        mk[2*i + pol] = 1'b1;
        set_term(0, mk, 1'b0);
        for (int v = 0; v < 2; v++) begin
          logic [NI-1:0] p;
          p = '1;
          p[i] = v[0];
          drive_pin(p);
          check_bit("R1 literal", sum_o[0], (pol == 1) ? ~v[0] : v[0]);
        end
      end
    end

    // R2: AND of in0..in3 true and in4 inverted, all 32 patterns
    set_term(1, 72'h2_55, 1'b0);
    set_row(1, 86'd2);
    for (int p = 0; p < 32; p++) begin
      drive_pin(36'(p));
      check_bit("R2 and", sum_o[1], (p == 15));
      check_all("R2 full");
    end

    // R3: empty term with and without enable
    set_term(2, '0, 1'b1);
    set_row(3, 86'd4);
    drive_pin('0);
    check_bit("R3 enabled", sum_o[3], 1'b1);
    set_term(2, '0, 1'b0);
    drive_pin('0);
    check_bit("R3 disabled", sum_o[3], 1'b0);
    // R8: out-of-range term and masked steer bits ignored
    wr(10'd511, 32'hFFFF_FFFF);
    wr(10'(512 + 64), 32'hFFFF_FFFF);
    drive_pin('0);
    check_all("R8 ignored");

    // R5: term 1 shared by all macrocells; R4 rows without terms stay 0
    for (int m = 0; m < NM; m++) set_row(m, 86'd2);
    drive_pin(36'd15);
    check_bit("R5 all share", &sum_o, 1'b1);
    check_all("R5 full");
    set_row(7, '0);
    drive_pin(36'd15);
    check_bit("R4 empty row", sum_o[7], 1'b0);
    check_all("R4 full");

    // R6/R7: 20 terms on macrocell 2, term t tests input t
    for (int t = 0; t < 20; t++) begin
      logic [NL-1:0] mk;
      mk = '0;
      mk[2*t] = 1'b1;
      set_term(t, mk, 1'b0);
    end
    set_row(2, 86'hF_FFFF);
    for (int j = 0; j < 20; j++) begin
      drive_pin(36'd1 << j);
      check_bit("R6 truncate", sum_o[2], (j < MX));
      check_bit("R6 flag", over_o[2], 1'b1);
      check_bit("R7 slot", steer_o[2*MX + (j % MX)], (j < MX));
      check_all("R7 full");
    end

    // Randomised configurations: sharing and overflow in one evaluation
    for (int rnd = 0; rnd < 5; rnd++) begin
      for (int t = 0; t < NP; t++) begin
        logic [NL-1:0] mk;
        mk = '0;
        for (int k = 0; k < 2; k++)
          if (($urandom % 3) != 0) mk[$urandom % NL] = 1'b1;
        set_term(t, mk, 1'($urandom % 2));
      end
      for (int m = 0; m < NM; m++) begin
        logic [NP-1:0] r;
        int dens;
        r = '0;
        dens = ((m % 4) == 0) ? 3 : 12;
        for (int t = 0; t < NP; t++)
          if (($urandom % dens) == 0) r[t] = 1'b1;
        set_row(m, r);
      end
      for (int k = 0; k < 20; k++) begin
        drive_pin({4'($urandom), 32'($urandom)});
        check_all("R6 R5 R9 random");
      end
    end

    done = 1;
    finish_run();
  end

endmodule